// File: doc/BRIEF.md
# PCI/SRC Clock Stop Sequencer

This block sits between the clock sources and the output buffers of a system clock generator. It gates six 33 MHz PCI clocks, two PCIF clocks and eight differential 100 MHz SRC outputs. The gating responds to an active-low stop pin and a software stop bit. A stop request parks the PCI-type clocks low first. Only after that do the stoppable SRC outputs park, with the true side high and the complement low, or with their drivers released. On release the SRC outputs restart before the PCI-type clocks. Every transition lands on a clock boundary, so no output ever shows a shortened pulse.

Each output has an enable. Each SRC output has a free-running bit and a float-when-stopped bit. Each PCIF output has a stoppable bit. The six PCI clocks are always stoppable. The stop request is formed in the free-running PCIF domain. It crosses into the PCI and SRC domains through two-flop synchronizers. A "parked" indication travels the other way the same way, and so does an "SRC active" indication.

Top module: `pcistop_seq`

## Requirements
- R1: The stop request is the OR of the inverted stop pin (`stop_n_i` low means stop) and `sw_stop_i`, both taken through two flops clocked on the rising edge of the PCIF clock. With no request, every enabled output follows its source clock.
- R2: When the request is seen, each enabled PCI clock and each PCIF clock whose stoppable bit is 1 ends its current high phase at the next falling edge of its source and then stays low.
- R3: Stoppable SRC outputs stop only after both the PCI and PCIF groups report parked, through a two-flop synchronizer, at a rising edge of the SRC clock. A stopped output holds true = 1 and complement = 0, and its output enable is 0 when its float bit is 1.
- R4: An SRC output whose free-running bit is 1 keeps toggling during a stop. A PCIF output whose stoppable bit is 0 keeps toggling during a stop.
- R5: Setting `sw_stop_i` with the pin high stops the same outputs as the pin.
- R6: On release, the SRC outputs resume first. The PCI and PCIF clocks resume only after the SRC domain reports it is no longer stopping. No output shows a high or low phase shorter than half of its source period.
- R7: An output enable of 0 holds a PCI or PCIF clock low. It drives both SRC sides low with the SRC output enable at 0, whatever the stop state. During reset the PCI and PCIF clocks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pcif_i | input | 1 | Free-running PCIF source clock; stop request domain |
| clk_pci_i | input | 1 | PCI source clock |
| clk_src_i | input | 1 | SRC source clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| stop_n_i | input | 1 | Stop pin, active low |
| sw_stop_i | input | 1 | Software stop bit, active high |
| pci_en_i | input | 6 | Per-PCI-clock enable |
| pcif_en_i | input | 2 | Per-PCIF-clock enable |
| pcif_stop_ok_i | input | 2 | 1 = PCIF clock obeys stop |
| src_en_i | input | 8 | Per-SRC enable |
| src_free_i | input | 8 | 1 = SRC output ignores stop |
| src_float_i | input | 8 | 1 = SRC output released when stopped |
| pci_clk_o | output | 6 | Gated PCI clocks |
| pcif_clk_o | output | 2 | Gated PCIF clocks |
| src_t_o | output | 8 | SRC true side |
| src_c_o | output | 8 | SRC complement side |
| src_oe_o | output | 8 | SRC driver enable |

## Verification
The sweep runs three stop sources: the pin alone, the software bit alone, and both together. Each source is paired with a different mix of free-running, float, stoppable and disabled bits. Every output is sampled at a fine step, away from all edges. Each output is then classed as toggling, held high or held low, and that class tells a stopped output apart from a running or disabled one. Edge-time monitors on one output of each group show the stop order (SRC parks after PCI) and the resume order (SRC first). They also show that no pulse is shortened.

// File: rtl/pcistop_pkg.sv
`timescale 1ns/1ps
package pcistop_pkg;
    localparam int NUM_PCI_DEF  = 6;
    localparam int NUM_PCIF_DEF = 2;
    localparam int NUM_SRC_DEF  = 8;
    localparam int SYNC_DEPTH   = 2;
endpackage

// File: rtl/pcistop_sync.sv
`timescale 1ns/1ps
module pcistop_sync #(
    parameter int W      = 1,
    parameter int STAGES = pcistop_pkg::SYNC_DEPTH
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) pipe_q <= '0;
        else          pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pcistop_lowgate.sv
`timescale 1ns/1ps
module pcistop_lowgate #(
    parameter int W        = 6,
    parameter bit REQ_SYNC = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         req_i,
    input  logic         blk_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] stop_ok_i,
    output logic [W-1:0] gclk_o,
    output logic         parked_o
);
    typedef struct packed {
        logic         park;
        logic [W-1:0] run;
    } gate_t;

    gate_t g_d, g_q;
    logic  req_l;
    logic  blk_l;

    generate
        if (REQ_SYNC) begin : g_req_sync
            pcistop_sync #(.W(1)) u_req_sync (
                .clk_i(clk_i), .rst_n_i(rst_n_i), .d_i(req_i), .q_o(req_l)
            );
        end else begin : g_req_local
            assign req_l = req_i;
        end
    endgenerate

    pcistop_sync #(.W(1)) u_blk_sync (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .d_i(blk_i), .q_o(blk_l)
    );

    always_comb begin
        g_d = g_q;
        if (req_l)       g_d.park = 1'b1;
        else if (!blk_l) g_d.park = 1'b0;
        g_d.run = en_i & ~({W{g_d.park}} & stop_ok_i);
    end

    always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) g_q <= '0;
        else          g_q <= g_d;
    end

    assign gclk_o   = {W{clk_i}} & g_q.run;
    assign parked_o = g_q.park;

    AST_PARK_ON_REQ: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        $past(req_l) |-> g_q.park); // R2
    AST_PARKED_OUT_LOW: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        (g_q.park && $stable(stop_ok_i) && $past(g_q.park)) |-> ((gclk_o & stop_ok_i) == '0)); // R2
    AST_RESUME_WAITS_SRC: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        $fell(g_q.park) |-> (!$past(blk_l) && !$past(req_l))); // R6
endmodule

// File: rtl/pcistop_srcgate.sv
`timescale 1ns/1ps
module pcistop_srcgate #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         req_i,
    input  logic         pk_a_i,
    input  logic         pk_b_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] free_i,
    input  logic [W-1:0] float_i,
    output logic [W-1:0] true_o,
    output logic [W-1:0] comp_o,
    output logic [W-1:0] oe_o,
    output logic         active_o
);
    typedef struct packed {
        logic         act;
        logic [W-1:0] stop;
    } src_t;

    src_t       s_d, s_q;
    logic [2:0] in_s;
    logic       req_s, pk_s;
    logic [W-1:0] level;

    pcistop_sync #(.W(3)) u_in_sync (
        .clk_i(clk_i), .rst_n_i(rst_n_i),
        .d_i({req_i, pk_a_i, pk_b_i}), .q_o(in_s)
    );
    assign req_s = in_s[2];
    assign pk_s  = in_s[1] & in_s[0];

    always_comb begin
        s_d      = s_q;
        s_d.act  = req_s & pk_s;
        s_d.stop = {W{s_d.act}} & ~free_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) s_q <= '0;
        else          s_q <= s_d;
    end

    assign level    = {W{clk_i}} | s_q.stop;
    assign true_o   = en_i & level;
    assign comp_o   = en_i & ~level;
    assign oe_o     = en_i & ~(s_q.stop & float_i);
    assign active_o = s_q.act;

    AST_SRC_NEEDS_PARK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        s_q.act |-> ($past(pk_s) && $past(req_s))); // R3
    AST_FREERUN_NOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $stable(free_i) |-> ((true_o & free_i) == '0)); // R4
endmodule

// File: rtl/pcistop_seq.sv
`timescale 1ns/1ps
module pcistop_seq #(
    parameter int NUM_PCI  = pcistop_pkg::NUM_PCI_DEF,
    parameter int NUM_PCIF = pcistop_pkg::NUM_PCIF_DEF,
    parameter int NUM_SRC  = pcistop_pkg::NUM_SRC_DEF
) (
    input  logic                clk_pcif_i,
    input  logic                clk_pci_i,
    input  logic                clk_src_i,
    input  logic                rst_n_i,
    input  logic                stop_n_i,
    input  logic                sw_stop_i,
    input  logic [NUM_PCI-1:0]  pci_en_i,
    input  logic [NUM_PCIF-1:0] pcif_en_i,
    input  logic [NUM_PCIF-1:0] pcif_stop_ok_i,
    input  logic [NUM_SRC-1:0]  src_en_i,
    input  logic [NUM_SRC-1:0]  src_free_i,
    input  logic [NUM_SRC-1:0]  src_float_i,
    output logic [NUM_PCI-1:0]  pci_clk_o,
    output logic [NUM_PCIF-1:0] pcif_clk_o,
    output logic [NUM_SRC-1:0]  src_t_o,
    output logic [NUM_SRC-1:0]  src_c_o,
    output logic [NUM_SRC-1:0]  src_oe_o
);
    localparam logic [NUM_PCI-1:0] PCI_ALL_STOP = '1;

    typedef struct packed {
        logic req;
    } ctl_t;

    ctl_t       c_d, c_q;
    logic [1:0] stop_s;
    logic       pci_parked, pcif_parked, src_active;

    pcistop_sync #(.W(2)) u_stop_sync (
        .clk_i(clk_pcif_i), .rst_n_i(rst_n_i),
        .d_i({sw_stop_i, ~stop_n_i}), .q_o(stop_s)
    );

    always_comb begin
        c_d     = c_q;
        c_d.req = stop_s[1] | stop_s[0];
    end

    always_ff @(posedge clk_pcif_i or negedge rst_n_i) begin
        if (!rst_n_i) c_q <= '0;
        else          c_q <= c_d;
    end

    pcistop_lowgate #(.W(NUM_PCI), .REQ_SYNC(1'b1)) u_pci_gate (
        .clk_i(clk_pci_i), .rst_n_i(rst_n_i), .req_i(c_q.req), .blk_i(src_active),
        .en_i(pci_en_i), .stop_ok_i(PCI_ALL_STOP),
        .gclk_o(pci_clk_o), .parked_o(pci_parked)
    );

    pcistop_lowgate #(.W(NUM_PCIF), .REQ_SYNC(1'b0)) u_pcif_gate (
        .clk_i(clk_pcif_i), .rst_n_i(rst_n_i), .req_i(c_q.req), .blk_i(src_active),
        .en_i(pcif_en_i), .stop_ok_i(pcif_stop_ok_i),
        .gclk_o(pcif_clk_o), .parked_o(pcif_parked)
    );

    pcistop_srcgate #(.W(NUM_SRC)) u_src_gate (
        .clk_i(clk_src_i), .rst_n_i(rst_n_i), .req_i(c_q.req),
        .pk_a_i(pci_parked), .pk_b_i(pcif_parked),
        .en_i(src_en_i), .free_i(src_free_i), .float_i(src_float_i),
        .true_o(src_t_o), .comp_o(src_c_o), .oe_o(src_oe_o), .active_o(src_active)
    );

    AST_REQ_FROM_INPUTS: assert property (@(posedge clk_pcif_i) disable iff (!rst_n_i)
        c_q.req |-> $past(stop_s != 2'b00)); // R1
endmodule

// File: tb/pcistop_seq_tb_top.sv
`timescale 1ns/1ps
module pcistop_seq_tb_top;
    logic clk_pcif = 1'b0, clk_pci = 1'b0, clk_src = 1'b0;
    logic rst_n = 1'b0;
    logic stop_n = 1'b1, sw_stop = 1'b0;
    logic [5:0] pci_en = '1;
    logic [1:0] pcif_en = '1, pcif_ok = '0;
    logic [7:0] src_en = '1, src_free = '0, src_float = '0;
    logic [5:0] pci_o;
    logic [1:0] pcif_o;
    logic [7:0] st_o, sc_o, oe_o;

    int total = 0, bad = 0, glitches = 0;
    bit done = 1'b0;

    always #2 clk_pcif = ~clk_pcif;
    initial begin #1; forever #2 clk_pci = ~clk_pci; end
    always #1.5 clk_src = ~clk_src;

    pcistop_seq dut_i (
        .clk_pcif_i(clk_pcif), .clk_pci_i(clk_pci), .clk_src_i(clk_src), .rst_n_i(rst_n),
        .stop_n_i(stop_n), .sw_stop_i(sw_stop), .pci_en_i(pci_en), .pcif_en_i(pcif_en),
        .pcif_stop_ok_i(pcif_ok), .src_en_i(src_en), .src_free_i(src_free),
        .src_float_i(src_float), .pci_clk_o(pci_o), .pcif_clk_o(pcif_o),
        .src_t_o(st_o), .src_c_o(sc_o), .src_oe_o(oe_o)
    );

    // pulse-width and ordering monitors on output 0 of each group
    realtime t_pci_r = 0, t_pcif_r = 0, t_src_r = 0, t_src_f = 0;
    realtime t_pci_fall_last = 0, t_src_rise_last = 0;
    realtime t_arm = 0, src_fall_first = 0, pci_rise_first = 0;

    always @(posedge pci_o[0]) begin
        t_pci_r = $realtime;
        if (pci_rise_first == 0 && $realtime > t_arm && t_arm > 0) pci_rise_first = $realtime;
    end
    always @(negedge pci_o[0]) begin
        if ($realtime - t_pci_r < 1.9) glitches++;
        t_pci_fall_last = $realtime;
    end
    always @(posedge pcif_o[0]) t_pcif_r = $realtime;
    always @(negedge pcif_o[0]) if ($realtime - t_pcif_r < 1.9) glitches++;
    always @(posedge st_o[0]) begin
        if (t_src_f > 0 && $realtime - t_src_f < 1.4) glitches++;
        t_src_r = $realtime;
        t_src_rise_last = $realtime;
    end
    always @(negedge st_o[0]) begin
        if (t_src_r > 0 && $realtime - t_src_r < 1.4) glitches++;
        t_src_f = $realtime;
        if (src_fall_first == 0 && $realtime > t_arm && t_arm > 0) src_fall_first = $realtime;
    end

    logic [5:0] p1, p0;
    logic [1:0] f1, f0;
    logic [7:0] t1, t0, c1, c0, e1, e0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic observe();
        p1 = '0; p0 = '0; f1 = '0; f0 = '0;
        t1 = '0; t0 = '0; c1 = '0; c0 = '0; e1 = '0; e0 = '0;
        #0.25;
        for (int k = 0; k < 48; k++) begin
            p1 |= pci_o;  p0 |= ~pci_o;
            f1 |= pcif_o; f0 |= ~pcif_o;
            t1 |= st_o;   t0 |= ~st_o;
            c1 |= sc_o;   c0 |= ~sc_o;
            e1 |= oe_o;   e0 |= ~oe_o;
            #0.5;
        end
        #0.25;
    endtask

    // tog: toggling mask, hi: held-high mask; all others expected held low
    task automatic chk_grp(input string req, input logic [7:0] s1, input logic [7:0] s0,
                           input logic [7:0] tog, input logic [7:0] hi, input logic [7:0] msk);
        logic [7:0] x1, x0;
        x1 = (tog | hi) & msk;
        x0 = (tog | ~hi) & msk;
        chk(((s1 & msk) == x1) && ((s0 & msk) == x0), req, {8'h0, s1 & msk, 8'h0, s0 & msk},
            {8'h0, x1, 8'h0, x0});
    endtask

    task automatic check_running(input string req);
        chk_grp({req, " pci"},  {2'b0, p1}, {2'b0, p0}, {2'b0, pci_en}, 8'h00, 8'h3F);
        chk_grp({req, " pcif"}, {6'b0, f1}, {6'b0, f0}, {6'b0, pcif_en}, 8'h00, 8'h03);
        chk_grp({req, " src_t"}, t1, t0, src_en, 8'h00, 8'hFF);
        chk_grp({req, " src_c"}, c1, c0, src_en, 8'h00, 8'hFF);
        chk_grp({req, " src_oe"}, e1, e0, 8'h00, src_en, 8'hFF);
    endtask

    task automatic check_stopped(input string req);
        logic [7:0] hold;
        hold = src_en & ~src_free;
        chk_grp({req, " pci parked low R2"}, {2'b0, p1}, {2'b0, p0}, 8'h00, 8'h00, 8'h3F);
        chk_grp({req, " pcif R2 R4"}, {6'b0, f1}, {6'b0, f0}, {6'b0, pcif_en & ~pcif_ok}, 8'h00, 8'h03);
        chk_grp({req, " src_t R3 R4 R7"}, t1, t0, src_en & src_free, hold, 8'hFF);
        chk_grp({req, " src_c R3 R4 R7"}, c1, c0, src_en & src_free, 8'h00, 8'hFF);
        chk_grp({req, " src_oe R3 R7"}, e1, e0, 8'h00, src_en & ~(hold & src_float), 8'hFF);
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #20;
        observe();
        // R7: reset holds the PCI-type clocks low
        chk((p1 == '0) && (f1 == '0), "R7 reset low", {24'h0, 2'b0, p1}, 32'h0);
        rst_n = 1'b1;
        for (int m = 0; m < 3; m++) begin
            string tag;
            tag = (m == 0) ? "pin" : (m == 1) ? "sw R5" : "pin+sw";
            src_free  = 8'h04 << m;
            src_float = 8'h02 | (8'h80 >> m);
            src_en    = ~(8'h10 << m);
            pci_en    = ~(6'h08 >> m);
            pcif_ok   = m[1:0];
            #30;
            glitches = 0;
            observe();
            check_running({"R1 R7 run ", tag});
            t_arm = 0;
            if (m != 1) stop_n = 1'b0;
            if (m != 0) sw_stop = 1'b1;
            #60;
            observe();
            check_stopped({"stop ", tag});
            chk(t_src_rise_last > t_pci_fall_last, "R3 src parks after pci",
                int'(t_src_rise_last), int'(t_pci_fall_last));
            src_fall_first = 0; pci_rise_first = 0;
            t_arm = $realtime;
            stop_n = 1'b1; sw_stop = 1'b0;
            #60;
            observe();
            check_running({"R6 resume ", tag});
            chk(src_fall_first > 0 && pci_rise_first > src_fall_first, "R6 src resumes first",
                int'(src_fall_first), int'(pci_rise_first));
            chk(glitches == 0, "R6 no short pulse", glitches, 0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule